// File: doc/BRIEF.md
# Edge-Capturing Push-Button Input Port

This block sits on a processor's word-addressed register bus and serves a small group of asynchronous inputs such as push buttons. It brings each input into the clock domain through a multi-stage synchroniser. It reports the current level of every input. Any change on an input, rising or falling, sets a sticky per-bit capture flag.

Software arms individual inputs through an enable register. A single level interrupt request is raised whenever an armed input has a capture flag set. The handler reads the capture register and writes the same value back. Each bit written as 1 clears its flag, and each bit written as 0 keeps its flag. The request stays high until every armed flag has been cleared.

All read data and the interrupt request come from registers. A read returns data on the clock edge after the address is presented.

Top module: `edge_input_port`

## Requirements
- R1: While reset is high and on the first cycle after it, the enable register, the capture register, the interrupt request and the read data are all 0.
- R2: A read at word offset 0 returns the synchronised input levels in bits [W-1:0] and zeros above. An input change shows up in a read started 3 or more cycles later.
- R3: Word offset 2 is the enable register. A write stores wdata[W-1:0], a read returns that value zero-extended, and bits written above W-1 read back as 0.
- R4: Word offset 1 always reads 0. Writes to offsets 0 and 1 change no register.
- R5: A capture bit (offset 3, bit i for input i) becomes 1 after input i changes in either direction. It then stays 1 until it is cleared by a write.
- R6: A write to offset 3 clears every capture bit whose wdata bit is 1 and leaves every bit whose wdata bit is 0 unchanged.
- R7: If a new change on input i arrives in the same cycle as a clearing write to capture bit i, the bit stays 1.
- R8: The interrupt request is the OR over i of (capture[i] AND enable[i]), taken from a register. It follows a change of either operand one cycle later.
- R9: The interrupt request stays high until the enabled capture bits are cleared or their enable bits are removed. Clearing with 0 data does not lower it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | W | Asynchronous input levels |
| bus_addr | input | AW | Word offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered level interrupt request |

## Verification
The hardest corner is a clearing write that lands in the very cycle a fresh change is detected. A design that gives priority to the clear loses that press, and the capture register reads 0 afterwards.

Clearing with the data just read must be selective. A design that clears the whole register on any write, or treats a 0 as a clear, wipes bits that software never acknowledged.

The bench checks that the request appears exactly one cycle after the enable write, so a combinational or doubly registered request is caught. It checks that writes to the data and reserved offsets leave the enable register alone, which catches sloppy decoding. It also checks that changes in both directions are captured, which catches a rising-only detector.

// File: rtl/edge_input_port_pkg.sv
package edge_input_port_pkg;
  localparam int OFS_LEVEL  = 0;
  localparam int OFS_RSVD   = 1;
  localparam int OFS_ENABLE = 2;
  localparam int OFS_CAPT   = 3;

  typedef enum logic [1:0] {
    SEL_LEVEL  = 2'd0,
    SEL_RSVD   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_CAPT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sample_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] cap_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sample_i;
  end

  assign chg_o = sample_i ^ prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                           cap_q[i] <= 1'b0;
      else if (chg_o[i])                 cap_q[i] <= 1'b1;
      else if (clr_en_i && clr_bits_i[i]) cap_q[i] <= 1'b0;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/port_regs.sv
module port_regs
  import edge_input_port_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [W-1:0]  level_i,
  input  logic [W-1:0]  cap_i,
  output logic [W-1:0]  enable_o,
  output logic          clr_en_o,
  output logic [W-1:0]  clr_bits_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [W-1:0]  enable_q;
  logic [DW-1:0] rd_next;
  logic          hit_enable;

  assign hit_enable = wr_i && (addr_i == AW'(OFS_ENABLE));
  assign clr_en_o   = wr_i && (addr_i == AW'(OFS_CAPT));
  assign clr_bits_o = wdata_i[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)             enable_q <= '0;
    else if (hit_enable) enable_q <= wdata_i[W-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == AW'(OFS_LEVEL))       rd_next[W-1:0] = level_i;
    else if (addr_i == AW'(OFS_ENABLE)) rd_next[W-1:0] = enable_q;
    else if (addr_i == AW'(OFS_CAPT))   rd_next[W-1:0] = cap_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_next;
      irq_o   <= |(cap_i & enable_q);
    end
  end

  assign enable_o = enable_q;
endmodule

// File: rtl/edge_input_port.sv
module edge_input_port #(
  parameter int W      = 4,
  parameter int AW     = 2,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  pins_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [W-1:0] level;
  logic [W-1:0] chg;
  logic [W-1:0] cap_q;
  logic [W-1:0] enable_q;
  logic         clr_en;
  logic [W-1:0] clr_bits;

  pin_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pins_in), .sync_o(level)
  );

  edge_capture #(.W(W)) u_capt (
    .clk(clk), .rst(rst), .sample_i(level), .clr_en_i(clr_en),
    .clr_bits_i(clr_bits), .chg_o(chg), .cap_o(cap_q)
  );

  port_regs #(.W(W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .level_i(level), .cap_i(cap_q),
    .enable_o(enable_q), .clr_en_o(clr_en), .clr_bits_o(clr_bits),
    .rdata_o(bus_rdata), .irq_o(irq)
  );
endmodule

// File: rtl/edge_input_port_props.sv
module edge_input_port_props #(
  parameter int W  = 4,
  parameter int AW = 2,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq,
  input logic [W-1:0]  cap,
  input logic [W-1:0]  enable,
  input logic [W-1:0]  chg
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cap == '0 && enable == '0 && !irq));

  // R8
  a_r8_irq_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(cap) & $past(enable))));

  // R5
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(3)) |=> ((cap & $past(cap)) == $past(cap)));

  // R7
  a_r7_change_sets: assert property (@(posedge clk) disable iff (rst)
    (|chg) |=> ((cap & $past(chg)) == $past(chg)));

  // R6
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(3)) |=>
      ((cap & $past(bus_wdata[W-1:0]) & ~$past(chg)) == '0));

  // R4
  a_r4_enable_held: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(2)) |=> $stable(enable));
endmodule

bind edge_input_port edge_input_port_props #(.W(W), .AW(AW), .DW(DW)) u_props (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq(irq), .cap(cap_q), .enable(enable_q), .chg(chg)
);

// File: tb/sim_edge_input_port.sv
module sim_edge_input_port;
  localparam int W = 4, AW = 2, DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  pins_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_input_port #(.W(W), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .pins_in(pins_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int ofs, output logic [DW-1:0] v);
    @(negedge clk); bus_addr = AW'(ofs);
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic wr(input int ofs, input logic [DW-1:0] d);
    @(negedge clk); bus_addr = AW'(ofs); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic set_pins(logic [W-1:0] p);
    @(negedge clk); pins_in = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    for (int k = 0; k < 4; k++) begin
      rd(k, v); check("R1 reg", v, 0);
    end
  endtask

  task automatic t_level_capture;
    logic [DW-1:0] v;
    set_pins(4'b1010);
    rd(0, v); check("R2 level", v, 32'hA);
    rd(3, v); check("R5 rising", v, 32'hA);
    set_pins(4'b0101);
    rd(0, v); check("R2 level", v, 32'h5);
    rd(3, v); check("R5 both dirs sticky", v, 32'hF);
  endtask

  task automatic t_w1c;
    logic [DW-1:0] v;
    wr(3, 0);      rd(3, v); check("R6 zero keeps", v, 32'hF);
    wr(3, 32'h3);  rd(3, v); check("R6 partial", v, 32'hC);
    wr(3, 32'hC);  rd(3, v); check("R6 rest", v, 32'h0);
  endtask

  task automatic t_enable_decode;
    logic [DW-1:0] v;
    wr(2, 32'hFFFF_FFF5); rd(2, v); check("R3 enable", v, 32'h5);
    wr(0, 32'hFF); wr(1, 32'hFF);
    rd(1, v); check("R4 rsvd", v, 0);
    rd(2, v); check("R4 enable kept", v, 32'h5);
    rd(0, v); check("R4 level kept", v, 32'h5);
    rd(3, v); check("R4 capture kept", v, 0);
  endtask

  task automatic t_irq;
    logic [DW-1:0] v;
    set_pins(4'b0111);
    check("R8 masked", {31'b0, irq}, 0);
    @(negedge clk); bus_addr = 2'd2; bus_wdata = 32'h2; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R8 one cycle lag", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 raised", {31'b0, irq}, 1);
    wr(3, 0); repeat (3) @(negedge clk);
    check("R9 held", {31'b0, irq}, 1);
    wr(3, 32'h2); @(negedge clk);
    check("R9 cleared", {31'b0, irq}, 0);
    set_pins(4'b0101);
    check("R8 again", {31'b0, irq}, 1);
    wr(2, 0); @(negedge clk);
    check("R9 unmasked", {31'b0, irq}, 0);
    wr(3, 32'hF); rd(3, v); check("R6 all", v, 0);
  endtask

  task automatic t_collide;
    logic [DW-1:0] v;
    set_pins(4'b0100);
    rd(3, v); check("R5 bit0", v, 32'h1);
    @(negedge clk); pins_in = 4'b0101;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 2'd3; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(3, v); check("R7 change wins", v, 32'h1);
    wr(3, 32'h1); rd(3, v); check("R7 later clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_level_capture();
    t_w1c();
    t_enable_decode();
    t_irq();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule